// File: doc/BRIEF.md
# Frequency-Locked Spindle Speed Regulator

This block is the digital half of a frequency-locked loop that holds a spindle motor at a programmed speed. It counts system-clock cycles between successive timing events from the commutation logic. The events come either once per electrical cycle or once per mechanical revolution, chosen by a select input. At each event it compares the count with a target period. If the two differ, it drives one charge pump control line high for a number of cycles equal to the difference, limited to a ceiling. A longer period means the motor is slow, so the block sources charge. A shorter period means the motor is fast, so it sinks charge. The speed correction is applied once per cycle, not continuously.

The two charge pump lines double as the up and down status bits. A sticky at-speed flag is set by the first down pulse the loop issues. Only reset clears it, which stands for power-on reset. A bypass input lets an external reference clock take over speed control: while bypass is high, the block keeps measuring periods but issues no pulses. Two register fields pass straight through to the analog side: a control bit that shorts the charge pump resistor for fast settling, and the charge pump gain code.

Top module: `spd_fll`

## Requirements
- R1: While reset is low, and right after it is released, pump_up, pump_dn and at_speed are all 0.
- R2: The first accepted timing event after reset only starts a measurement and produces no pulse on either pump line.
- R3: The measured period is the number of rising clock edges from one accepted event to the next. When it exceeds target, pump_up goes high on the clock edge that samples the event. It stays high for exactly (period - target) cycles.
- R4: When the measured period is below target, pump_dn goes high on the edge that samples the event. It stays high for exactly (target - period) cycles.
- R5: When the measured period equals target, no pulse is produced.
- R6: A pulse width never exceeds the parameter MAXW; a larger difference gives a pulse of exactly MAXW cycles.
- R7: The period counter saturates at 2**CW-1. An event that finds the counter at that value is an overflow. An overflow gives an up pulse of exactly MAXW cycles, whatever the target.
- R8: at_speed rises together with the first down pulse and stays 1 until reset, whatever pulses follow.
- R9: When use_mech is 0, only tick_elec events are accepted. When use_mech is 1, only tick_mech events are accepted. An event on the other input has no effect on the measurement or the pump lines.
- R10: While bypass is high, pump_up and pump_dn are held at 0 from the next clock edge on. Any pulse in progress is cut off, and events sampled then produce no pulse. at_speed is unchanged.
- R11: short_out follows short_req and gain_out follows gain_in combinationally, unchanged.
- R12: pump_up and pump_dn are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick_elec | input | 1 | One-cycle pulse per electrical cycle |
| tick_mech | input | 1 | One-cycle pulse per mechanical revolution |
| use_mech | input | 1 | 1 selects tick_mech as the timing source, 0 selects tick_elec |
| bypass | input | 1 | 1 hands speed control to an external reference and suppresses pulses |
| target | input | CW | Target period in clock cycles |
| short_req | input | 1 | Register bit requesting the charge pump resistor short |
| gain_in | input | GW | Charge pump gain code from the register |
| pump_up | output | 1 | Source-charge pulse, also the up status bit |
| pump_dn | output | 1 | Sink-charge pulse, also the down status bit |
| at_speed | output | 1 | Sticky flag, set by the first down pulse |
| short_out | output | 1 | Drive to the resistor shorting switch |
| gain_out | output | GW | Gain code passed to the charge pump DAC |

## Verification
The hardest state to reach is a saturated period counter, which needs a gap between events longer than the full counter range. The bench uses a narrow counter width, waits more than 2**CW cycles between two accepted events, and sets a target close to the saturation value. Without the overflow rule the difference would be small. If the counter wrapped instead of saturating, the pulse would go the wrong way. Only the full-width up pulse passes. Pulses are counted during the gap before the following event, so every gap in the stimulus table is chosen to be at least as long as the pulse that precedes it.

// File: rtl/spd_fll.sv
module spd_fll #(
  parameter int CW   = 16,
  parameter int MAXW = 255,
  parameter int GW   = 5,
  localparam int WW  = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_elec,
  input  logic          tick_mech,
  input  logic          use_mech,
  input  logic          bypass,
  input  logic [CW-1:0] target,
  input  logic          short_req,
  input  logic [GW-1:0] gain_in,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          at_speed,
  output logic          short_out,
  output logic [GW-1:0] gain_out
);

  localparam logic [CW-1:0] FULL = '1;
  localparam logic [CW-1:0] CAPC = CW'(MAXW);
  localparam logic [WW-1:0] CAPW = WW'(MAXW);

  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic          primed;
  logic          dir_up;

  logic          tick, ovf, slow, fast, fire;
  logic [CW-1:0] diff;
  logic [WW-1:0] wsel;

  assign tick = use_mech ? tick_mech : tick_elec;
  assign ovf  = (cnt == FULL);
  assign slow = ovf || (cnt > target);
  assign fast = !ovf && (cnt < target);
  assign diff = slow ? (cnt - target) : (target - cnt);
  assign wsel = (ovf || diff > CAPC) ? CAPW : diff[WW-1:0];
  assign fire = tick && primed && !bypass && (slow || fast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      primed   <= 1'b0;
      wcnt     <= '0;
      dir_up   <= 1'b0;
      at_speed <= 1'b0;
    end else begin
      if (tick) begin
        cnt    <= CW'(1);
        primed <= 1'b1;
      end else if (!ovf) begin
        cnt <= cnt + 1'b1;
      end

      if (bypass) begin
        wcnt <= '0;
      end else if (fire) begin
        wcnt   <= wsel;
        dir_up <= slow;
      end else if (wcnt != '0) begin
        wcnt <= wcnt - 1'b1;
      end

      if (fire && fast) at_speed <= 1'b1;
    end
  end

  assign pump_up   = dir_up  && (wcnt != '0);
  assign pump_dn   = !dir_up && (wcnt != '0);
  assign short_out = short_req;
  assign gain_out  = gain_in;

endmodule

// File: rtl/spd_fll_chk.sv
module spd_fll_chk (
  input logic clk,
  input logic rst_n,
  input logic bypass,
  input logic pump_up,
  input logic pump_dn,
  input logic at_speed
);

  // R12
  excl_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  // R8
  sticky_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_speed |=> at_speed);

  // R8
  speed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_speed) |-> pump_dn);

  // R10
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (!pump_up && !pump_dn));

  // R4
  down_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_dn) |-> at_speed);

endmodule

bind spd_fll spd_fll_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bypass   (bypass),
  .pump_up  (pump_up),
  .pump_dn  (pump_dn),
  .at_speed (at_speed)
);

// File: tb/test_spd_fll.sv
module test_spd_fll;
  localparam int CW   = 10;
  localparam int MAXW = 40;
  localparam int GW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_elec = 1'b0, tick_mech = 1'b0, use_mech = 1'b0, bypass = 1'b0;
  logic [CW-1:0] target = '0;
  logic          short_req = 1'b0;
  logic [GW-1:0] gain_in = '0;
  logic          pump_up, pump_dn, at_speed, short_out;
  logic [GW-1:0] gain_out;

  spd_fll #(.CW(CW), .MAXW(MAXW), .GW(GW)) i_spd_fll (
    .clk(clk), .rst_n(rst_n), .tick_elec(tick_elec), .tick_mech(tick_mech),
    .use_mech(use_mech), .bypass(bypass), .target(target), .short_req(short_req),
    .gain_in(gain_in), .pump_up(pump_up), .pump_dn(pump_dn), .at_speed(at_speed),
    .short_out(short_out), .gain_out(gain_out)
  );

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int nu, nd;

  // gap, target, expected up width, expected down width, at_speed after the event
  localparam int VEC [8][5] = '{
    '{ 50,  50,  0,  0, 0},
    '{ 60,  50, 10,  0, 0},
    '{ 45,  50,  0,  5, 1},
    '{ 70,  70,  0,  0, 1},
    '{100,  30, 40,  0, 1},
    '{ 50, 120,  0, 40, 1},
    '{ 60,  57,  3,  0, 1},
    '{ 45,  45,  0,  0, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts pump cycles for gap negedges; src 1/2 fires tick_elec/tick_mech on the last edge.
  task automatic gap_tick(input int gap, input int src, output int cu, output int cd);
    cu = 0; cd = 0;
    for (int c = 0; c < gap; c++) begin
      @(negedge clk);
      if (pump_up) cu++;
      if (pump_dn) cd++;
      if (pump_up && pump_dn) chk("R12 both high", 1, 0);
      if (c == gap - 1) begin
        if (src == 1) tick_elec = 1'b1;
        if (src == 2) tick_mech = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    tick_elec = 1'b0;
    tick_mech = 1'b0;
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #11;
    chk("R1 pump_up in reset", int'(pump_up), 0);
    chk("R1 pump_dn in reset", int'(pump_dn), 0);
    chk("R1 at_speed in reset", int'(at_speed), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      target = CW'(VEC[i][1]);
      gap_tick(VEC[i][0], 1, nu, nd);
      if (i == 0) begin
        chk("R1 up after reset", nu, 0);
        chk("R1 dn after reset", nd, 0);
      end else begin
        chk("R3 R6 up width", nu, VEC[i-1][2]);
        chk("R4 R5 dn width", nd, VEC[i-1][3]);
      end
      chk("R8 at_speed", int'(at_speed), VEC[i][4]);
    end

    use_mech = 1'b1;
    gap_tick(30, 1, nu, nd);
    chk("R5 equal up", nu, 0);
    chk("R5 equal dn", nd, 0);
    gap_tick(20, 2, nu, nd);
    chk("R9 ignored tick up", nu, 0);
    chk("R9 ignored tick dn", nd, 0);
    target = CW'(80);
    gap_tick(40, 2, nu, nd);
    chk("R9 mech period up", nu, 5);
    chk("R9 mech period dn", nd, 0);

    gap_tick(10, 0, nu, nd);
    chk("R4 dn before bypass", nd, 10);
    bypass = 1'b1;
    gap_tick(30, 2, nu, nd);
    chk("R10 dn cut by bypass", nd, 1);
    chk("R10 up in bypass", nu, 0);
    #1 bypass = 1'b0;
    gap_tick(50, 0, nu, nd);
    chk("R10 event in bypass up", nu, 0);
    chk("R10 event in bypass dn", nd, 0);
    chk("R10 at_speed kept", int'(at_speed), 1);

    target = CW'(1000);
    gap_tick(1100, 2, nu, nd);
    chk("R7 quiet while counting", nu + nd, 0);
    gap_tick(60, 0, nu, nd);
    chk("R7 overflow up width", nu, MAXW);
    chk("R7 overflow dn", nd, 0);

    rst_n = 1'b0;
    #1;
    chk("R1 pump_up on reset", int'(pump_up), 0);
    chk("R8 at_speed cleared by reset", int'(at_speed), 0);
    @(negedge clk);
    rst_n = 1'b1;
    target = CW'(5);
    gap_tick(20, 2, nu, nd);
    gap_tick(30, 0, nu, nd);
    chk("R2 first event up", nu, 0);
    chk("R2 first event dn", nd, 0);
    gap_tick(15, 2, nu, nd);
    gap_tick(50, 0, nu, nd);
    chk("R2 R6 second event up", nu, MAXW);

    short_req = 1'b1; gain_in = 5'h13;
    #1;
    chk("R11 short_out high", int'(short_out), 1);
    chk("R11 gain_out", int'(gain_out), 'h13);
    short_req = 1'b0; gain_in = 5'h0A;
    #1;
    chk("R11 short_out low", int'(short_out), 0);
    chk("R11 gain_out second", int'(gain_out), 'h0A);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule